// File: doc/BRIEF.md
# Debug Register Move Unit

This block keeps eight 32-bit debug registers and carries out the two move instructions that transfer data between one of them and a general-purpose register. The surrounding pipeline presents the escape byte, the second opcode byte and the register-select byte, together with the 32-bit source operand from the register file and the current machine mode. It also drives a single request strobe. One cycle later the unit answers with exactly one outcome. Either a completion pulse arrives, carrying the read value and the target register number when the move was a read. Or exactly one of three fault flags is raised: general protection, undefined opcode or debug trap.

Two indices, 4 and 5, behave in one of two ways, chosen by an extension-control input. With the control clear they are aliases of registers 6 and 7. With it set they are illegal encodings. Every access is also subject to a privilege test. Bit 13 of register 7 acts as a global-detect lock: while it is set, every access traps, and only a reset clears it.

Top module: `dbg_move_unit`

## Requirements
- R1: After reset, registers 0 to 5 read as 0x00000000, register 6 reads as 0xFFFF0FF0 and register 7 reads as 0x00000400. All result and fault outputs are low.
- R2: A request with bytes 0x0F, 0x21 and a select byte whose bits 7:6 are 2'b11 is a read. In the next cycle `done_o` pulses, `res_data_o` holds the register chosen by select bits 5:3, `res_gpr_o` holds select bits 2:0, and `res_gpr_wr_o` is 1.
- R3: A request with bytes 0x0F, 0x23 and select bits 7:6 equal to 2'b11 is a write. All 32 bits of `gpr_wdata_i` go into the register chosen by bits 5:3 at the same clock edge that raises `done_o`. `res_gpr_wr_o` stays 0.
- R4: With `ext_fault_en_i` = 0, index 4 reads and writes register 6, and index 5 reads and writes register 7.
- R5: With `ext_fault_en_i` = 1, any access to index 4 or 5 raises `exc_ud_o` and transfers no data.
- R6: With `real_mode_i` = 0 and `cpl_i` nonzero, a request raises `exc_gp_o`, which implies error code 0. With `real_mode_i` = 1 the value of `cpl_i` has no effect.
- R7: A first byte other than 0x0F, a second byte other than 0x21 or 0x23, or select bits 7:6 other than 2'b11 raises `exc_ud_o`.
- R8: While bit 13 of register 7 is 1, any otherwise legal access, including one to register 7 itself, raises `exc_db_o` instead of completing.
- R9: Faults are ranked general protection, then undefined opcode, then debug trap. Exactly one of `done_o` and the three fault flags is high per request. A faulting request changes no register.
- R10: In a cycle with no request, the following cycle shows `done_o` and all fault flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request strobe, one cycle per move |
| op_b0_i | input | 8 | First opcode byte (escape) |
| op_b1_i | input | 8 | Second opcode byte (direction) |
| modrm_i | input | 8 | Register-select byte: mode 7:6, debug index 5:3, GPR index 2:0 |
| gpr_wdata_i | input | 32 | Source operand for writes |
| cpl_i | input | 2 | Current privilege level |
| real_mode_i | input | 1 | 1 when in real-address mode |
| ext_fault_en_i | input | 1 | 1 makes indices 4 and 5 illegal, 0 aliases them |
| done_o | output | 1 | Successful completion pulse |
| res_gpr_wr_o | output | 1 | Result must be written to a GPR (read move) |
| res_gpr_o | output | 3 | Destination GPR index |
| res_data_o | output | 32 | Value read from the debug register |
| exc_gp_o | output | 1 | General-protection fault |
| exc_ud_o | output | 1 | Undefined-opcode fault |
| exc_db_o | output | 1 | Debug trap from the global-detect lock |

## Verification
The global-detect state is the hardest to reach and to study. Once bit 13 of register 7 is set, every later access traps, so no register contents can be observed again until reset. The stimulus therefore runs every privilege, mode, extension and index combination first, keeping bit 13 clear in all written data. It then sets the lock with a deliberate write to register 7 and repeats the full sweep, including the illegal encodings, to check the fault ranking. Finally it resets and reads register 7 to confirm that the lock is gone.

// File: rtl/dbg_move_pkg.sv
package dbg_move_pkg;
  localparam int IDX_W = 3;
  localparam logic [7:0] OPC_ESC = 8'h0F;
  localparam logic [7:0] OPC_RD  = 8'h21;
  localparam logic [7:0] OPC_WR  = 8'h23;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_UD   = 2'd2,
    FLT_DB   = 2'd3
  } fault_e;

  // Power-on contents of each register slot.
  function automatic logic [31:0] rst_value(input int idx);
    case (idx)
      6:       rst_value = 32'hFFFF_0FF0;
      7:       rst_value = 32'h0000_0400;
      default: rst_value = 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/dbg_move_rst_sync.sv
module dbg_move_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dbg_move_decode.sv
module dbg_move_decode
  import dbg_move_pkg::*;
(
  input  logic [7:0]       op_b0,
  input  logic [7:0]       op_b1,
  input  logic [7:0]       modrm,
  input  logic [1:0]       cpl,
  input  logic             real_mode,
  input  logic             ext_fault_en,
  input  logic             gd_lock,
  output fault_e           fault,
  output logic             is_read,
  output logic [IDX_W-1:0] phys_idx,
  output logic [IDX_W-1:0] gpr_idx
);
  logic             bad_enc;
  logic             alias_hit;
  logic [IDX_W-1:0] sel;

  always_comb begin
    sel       = modrm[5:3];
    gpr_idx   = modrm[2:0];
    is_read   = (op_b1 == OPC_RD);
    bad_enc   = (op_b0 != OPC_ESC) || ((op_b1 != OPC_RD) && (op_b1 != OPC_WR)) ||
                (modrm[7:6] != 2'b11);
    alias_hit = (sel == 3'd4) || (sel == 3'd5);
    // 4 -> 6, 5 -> 7 by forcing bit 1
    phys_idx  = alias_hit ? (sel | 3'b010) : sel;

    if (!real_mode && (cpl != 2'd0))           fault = FLT_GP;
    else if (bad_enc || (ext_fault_en && alias_hit)) fault = FLT_UD;
    else if (gd_lock)                          fault = FLT_DB;
    else                                       fault = FLT_NONE;
  end
endmodule

// File: rtl/dbg_move_regbank.sv
module dbg_move_regbank
  import dbg_move_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DW     = 32,
  parameter int GD_POS = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DW-1:0]      rd_data,
  output logic               gd_lock,
  output logic [NREG*DW-1:0] bank_flat
);
  logic [DW-1:0] reg_q [NREG];
  logic [DW-1:0] reg_d [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_comb begin
      reg_d[g] = reg_q[g];
      if (wr_en && (wr_idx == IDX_W'(g))) reg_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= DW'(rst_value(g));
      else        reg_q[g] <= reg_d[g];
    end

    assign bank_flat[g*DW +: DW] = reg_q[g];
  end

  assign rd_data = reg_q[rd_idx];
  assign gd_lock = reg_q[NREG-1][GD_POS];

  // R3: the written word is present in the selected slot after the edge
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reg_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/dbg_move_unit.sv
module dbg_move_unit
  import dbg_move_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 8,
  parameter int GD_POS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic [7:0]       op_b0_i,
  input  logic [7:0]       op_b1_i,
  input  logic [7:0]       modrm_i,
  input  logic [DW-1:0]    gpr_wdata_i,
  input  logic [1:0]       cpl_i,
  input  logic             real_mode_i,
  input  logic             ext_fault_en_i,
  output logic             done_o,
  output logic             res_gpr_wr_o,
  output logic [IDX_W-1:0] res_gpr_o,
  output logic [DW-1:0]    res_data_o,
  output logic             exc_gp_o,
  output logic             exc_ud_o,
  output logic             exc_db_o
);
  logic               srst_n;
  fault_e             fault;
  logic               is_read;
  logic [IDX_W-1:0]   phys_idx;
  logic [IDX_W-1:0]   gpr_idx;
  logic               gd_lock;
  logic [DW-1:0]      rd_data;
  logic [NREG*DW-1:0] bank_flat;
  logic               ok;
  logic               wr_en;
  logic               rd_done;

  logic             done_d, gp_d, ud_d, db_d, res_wr_d;
  logic [IDX_W-1:0] res_gpr_d;
  logic [DW-1:0]    res_data_d;

  dbg_move_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  dbg_move_decode u_dec (
    .op_b0(op_b0_i), .op_b1(op_b1_i), .modrm(modrm_i),
    .cpl(cpl_i), .real_mode(real_mode_i), .ext_fault_en(ext_fault_en_i),
    .gd_lock(gd_lock), .fault(fault), .is_read(is_read),
    .phys_idx(phys_idx), .gpr_idx(gpr_idx)
  );

  dbg_move_regbank #(.NREG(NREG), .DW(DW), .GD_POS(GD_POS)) u_bank (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_idx(phys_idx),
    .wr_data(gpr_wdata_i), .rd_idx(phys_idx), .rd_data(rd_data),
    .gd_lock(gd_lock), .bank_flat(bank_flat)
  );

  // next-state
  always_comb begin
    ok         = req_valid_i && (fault == FLT_NONE);
    wr_en      = ok && !is_read;
    rd_done    = ok && is_read;
    done_d     = ok;
    res_wr_d   = rd_done;
    gp_d       = req_valid_i && (fault == FLT_GP);
    ud_d       = req_valid_i && (fault == FLT_UD);
    db_d       = req_valid_i && (fault == FLT_DB);
    res_gpr_d  = rd_done ? gpr_idx : res_gpr_o;
    res_data_d = rd_done ? rd_data : res_data_o;
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      done_o       <= 1'b0;
      res_gpr_wr_o <= 1'b0;
      exc_gp_o     <= 1'b0;
      exc_ud_o     <= 1'b0;
      exc_db_o     <= 1'b0;
      res_gpr_o    <= '0;
      res_data_o   <= '0;
    end else begin
      done_o       <= done_d;
      res_gpr_wr_o <= res_wr_d;
      exc_gp_o     <= gp_d;
      exc_ud_o     <= ud_d;
      exc_db_o     <= db_d;
      if (rd_done) begin
        res_gpr_o  <= res_gpr_d;
        res_data_o <= res_data_d;
      end
    end
  end

  // R9: at most one outcome per cycle
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({done_o, exc_gp_o, exc_ud_o, exc_db_o}));

  // R9: a fault never alters the register bank
  a_r9_fault_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (exc_gp_o || exc_ud_o || exc_db_o) |-> $stable(bank_flat));

  // R10: no request, no outcome
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    !req_valid_i |=> !(done_o || exc_gp_o || exc_ud_o || exc_db_o));

  // R6: protection fault only from protected mode with nonzero privilege
  a_r6_gp_cause: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid_i && (real_mode_i || (cpl_i == 2'd0)) |=> !exc_gp_o);

  // R8: a debug trap requires the lock bit to have been set
  a_r8_db_cause: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid_i && !gd_lock |=> !exc_db_o);

  // R2: a read result always comes with a completion
  a_r2_wr_with_done: assert property (@(posedge clk) disable iff (!srst_n)
    res_gpr_wr_o |-> done_o);
endmodule

// File: tb/dbg_move_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_move_unit_tb_top;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  op_b0, op_b1, modrm;
  logic [31:0] wdata;
  logic [1:0]  cpl;
  logic        real_mode, ext_en;
  logic        done, res_wr, exc_gp, exc_ud, exc_db;
  logic [2:0]  res_gpr;
  logic [31:0] res_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model [8];

  always #(CLK_P/2) clk = ~clk;

  dbg_move_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid),
    .op_b0_i(op_b0), .op_b1_i(op_b1), .modrm_i(modrm),
    .gpr_wdata_i(wdata), .cpl_i(cpl), .real_mode_i(real_mode),
    .ext_fault_en_i(ext_en), .done_o(done), .res_gpr_wr_o(res_wr),
    .res_gpr_o(res_gpr), .res_data_o(res_data),
    .exc_gp_o(exc_gp), .exc_ud_o(exc_ud), .exc_db_o(exc_db)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    model[6] = 32'hFFFF_0FF0;
    model[7] = 32'h0000_0400;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0;
    op_b0 = '0; op_b1 = '0; modrm = '0; wdata = '0;
    cpl = '0; real_mode = 1'b0; ext_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
  endtask

  // Drives one request at a falling edge, samples at the next falling edge.
  task automatic do_req(input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] mr, input logic [31:0] wd,
                        input logic [1:0] pl, input logic rm, input logic ex,
                        input string tag_hint);
    logic [2:0]  sel, phys;
    logic        badenc, alias4;
    logic [3:0]  exp_out;  // {done, gp, ud, db}
    string       tag;
    sel    = mr[5:3];
    alias4 = (sel == 3'd4) || (sel == 3'd5);
    phys   = (sel == 3'd4) ? 3'd6 : (sel == 3'd5) ? 3'd7 : sel;
    badenc = (b0 != 8'h0F) || ((b1 != 8'h21) && (b1 != 8'h23)) || (mr[7:6] != 2'b11);
    if (!rm && (pl != 2'd0))                    begin exp_out = 4'b0100; tag = "R6"; end
    else if (badenc)                            begin exp_out = 4'b0010; tag = "R7"; end
    else if (ex && alias4)                      begin exp_out = 4'b0010; tag = "R5"; end
    else if (model[7][13])                      begin exp_out = 4'b0001; tag = "R8"; end
    else if (b1 == 8'h21)                       begin exp_out = 4'b1000; tag = alias4 ? "R4" : "R2"; end
    else                                        begin exp_out = 4'b1000; tag = alias4 ? "R4" : "R3"; end
    if (tag_hint != "") tag = tag_hint;

    op_b0 = b0; op_b1 = b1; modrm = mr; wdata = wd;
    cpl = pl; real_mode = rm; ext_en = ex; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "outcome {done,gp,ud,db} (R9)", {60'h0, done, exc_gp, exc_ud, exc_db},
        {60'h0, exp_out});
    if (exp_out == 4'b1000 && b1 == 8'h21) begin
      chk(tag, "read data", {32'h0, res_data}, {32'h0, model[phys]});
      chk(tag, "gpr index", {61'h0, res_gpr}, {61'h0, mr[2:0]});
      chk(tag, "gpr write flag", {63'h0, res_wr}, 64'h1);
    end else begin
      chk(tag, "gpr write flag low", {63'h0, res_wr}, 64'h0);
      if (exp_out == 4'b1000) model[phys] = wd;
    end
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 8; i++)
      do_req(8'h0F, 8'h21, {2'b11, 3'(i), 3'(7 - i)}, 32'h0, 2'd3, 1'b1, 1'b0, tag);
  endtask

  task automatic full_sweep(input int salt);
    for (int op = 0; op < 2; op++)
      for (int p = 0; p < 4; p++)
        for (int r = 0; r < 2; r++)
          for (int e = 0; e < 2; e++)
            for (int s = 0; s < 8; s++) begin
              logic [31:0] wd;
              wd = (32'(salt + op*64 + p*16 + r*8 + e*4 + s) * 32'h9E37_79B1) & ~32'h0000_2000;
              do_req(8'h0F, op ? 8'h23 : 8'h21, {2'b11, 3'(s), 3'(s ^ 3)},
                     wd, 2'(p), 1'(r), 1'(e), "");
            end
  endtask

  task automatic bad_sweep();
    logic [7:0] b1s [4];
    b1s = '{8'h20, 8'h21, 8'h22, 8'h23};
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 4; k++)
        for (int m = 0; m < 4; m++)
          for (int p = 0; p < 2; p++)
            do_req(b ? 8'h0F : 8'h0E, b1s[k], {2'(m), 3'd2, 3'd1},
                   32'h1234_5678, 2'(p), 1'b0, 1'b0, "");
  endtask

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: quiet outputs and reset contents
    chk("R1", "outputs after reset", {59'h0, done, res_wr, exc_gp, exc_ud, exc_db}, 64'h0);
    read_all("R1");

    // R10: idle cycles with junk on the inputs
    op_b0 = 8'h0F; op_b1 = 8'h23; modrm = 8'hC0; cpl = 2'd3; wdata = 32'hDEAD_BEEF;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10", "idle outcome", {60'h0, done, exc_gp, exc_ud, exc_db}, 64'h0);
    end
    read_all("R10");

    full_sweep(1);
    read_all("R3");
    bad_sweep();
    full_sweep(77);
    read_all("R4");

    // Lock: write bit 13 of register 7 through alias index 5
    do_req(8'h0F, 8'h23, {2'b11, 3'd5, 3'd0}, 32'h0000_2400, 2'd0, 1'b0, 1'b0, "R4");
    do_req(8'h0F, 8'h21, {2'b11, 3'd7, 3'd0}, 32'h0, 2'd0, 1'b1, 1'b0, "R8");
    full_sweep(300);
    bad_sweep();

    // R1: reset removes the lock
    do_reset();
    read_all("R1");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule